// File: doc/BRIEF.md
# Iterative ARX Feistel Block Cipher Engine

This block encrypts or decrypts one 32-bit word under a 64-bit key. The word is split into four 8-bit branches and processed by a four-branch generalized Feistel network. The network uses only AND, rotation and XOR, and one round completes per clock over 16 rounds. A round-key generator runs alongside the datapath. It advances a 64-bit key register with a small LFSR constant, a nonlinear byte update and a fixed rotation, so that no round keys are stored.

A request is a single-cycle `start_i` with the data word, key and direction. Encryption produces its result 16 cycles after the accepting edge. For decryption, the engine first runs the key schedule forward for 16 cycles to reach the final key state. It then walks the schedule backward while undoing the rounds, so a decryption takes 32 cycles. `done_o` pulses for one cycle, and `result_o` keeps the last result until the next one is written.

Top module: `arxf_core`

## Requirements
- R1: While reset is asserted and after its release, `done_o` is 0 and `result_o` is 0 until a first operation completes.
- R2: With `decrypt_i`=0, the bits of `block_i` map to branches as [31:24]=L0, [23:16]=L1, [15:8]=R0, [7:0]=R1. With f(x) = (rotl(x,1) AND rotl(x,7)) XOR rotl(x,2), each round computes s0 = f(L0)^L1^rk0 and s1 = f(R0)^R1^rk1. The new state is L0'=s0, L1'=f(s0)^L0^rk2, R0'=s1, R1'=f(s1)^R0^rk3. `result_o` packs the state back in the same order.
- R3: In every round except the 16th, the new L1 is rotated left by 1 and the new R1 by 7 before the next round. In round 16 both rotations are skipped.
- R4: Round r (1..16) takes its key from a 64-bit register k that starts as `key_i`. The register is updated in four steps. First, k[7:3] ^= rc. Second, the top byte k[63:56]=(h,l), split into nibbles, is updated as h ^= l & rotl4(l,1), and then l ^= h & rotl4(h,1). Third, k is rotated left by 8. Fourth, the round key is taken as rk0=k[63:56], rk1=k[55:48], rk2=k[47:40], rk3=k[39:32].
- R5: rc is 5 bits wide. It is 5'b00001 in round 1 and then steps as rc' = {rc[3:0], rc[4]^rc[2]}.
- R6: With `decrypt_i`=1, the result is the word that encryption under the same key maps to `block_i`, so decrypt(encrypt(P)) = P.
- R7: `done_o` rises exactly 16 cycles after the accepting `start_i` edge for encryption and exactly 32 cycles after it for decryption.
- R8: `done_o` is high for a single cycle per operation. `result_o` does not change on any cycle where `done_o` is low.
- R9: `start_i` is ignored while an operation is running. Inputs are latched at the accepting edge, so changes to `block_i`, `key_i` or `decrypt_i` later in the run do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an operation (accepted only when idle) |
| decrypt_i | input | 1 | 0 = encrypt, 1 = decrypt |
| key_i | input | 64 | Master key |
| block_i | input | 32 | Plaintext or ciphertext word |
| result_o | output | 32 | Result word, held until the next result |
| done_o | output | 1 | One-cycle pulse when the result is written |

## Verification
The bench drives random and extreme words and keys through both directions. It checks each result against a loop-based model of the round and key schedule, and checks that decryption returns the original word. The last-round rotation skip is a key corner. A design that rotates in round 16, or un-rotates on the wrong decryption step, gives wrong ciphertexts or fails to invert, even though its first 15 rounds are correct. A key schedule whose inverse does not undo the forward step, or whose LFSR runs backward from the wrong point, breaks only decryption. The bench also pulses start with altered inputs in the middle of a run, and it measures the exact cycle of `done_o`. An engine that restarted, re-latched its inputs or was off by one round would show up as a wrong value or a wrong latency.

// File: rtl/arxf_pkg.sv
package arxf_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_PREP = 2'd1,
      PH_RUN  = 2'd2
   } phase_e;

endpackage

// File: rtl/arxf_round.sv
module arxf_round #(
   parameter int BRANCH_W = 8,
   parameter int F_ROT_A  = 1,
   parameter int F_ROT_B  = 7,
   parameter int F_ROT_C  = 2,
   parameter int ROT_L1   = 1,
   parameter int ROT_R1   = 7,
   localparam int BLOCK_W = 4 * BRANCH_W
) (
   input  logic [BLOCK_W-1:0] blk_i,
   input  logic [BLOCK_W-1:0] rk_i,
   input  logic               dec_i,
   input  logic               last_i,
   output logic [BLOCK_W-1:0] blk_o
);

   function automatic logic [BRANCH_W-1:0] rotl(input logic [BRANCH_W-1:0] v, input int n);
      int m;
      m = n % BRANCH_W;
      if (m == 0) return v;
      return (v << m) | (v >> (BRANCH_W - m));
   endfunction

   function automatic logic [BRANCH_W-1:0] rotr(input logic [BRANCH_W-1:0] v, input int n);
      return rotl(v, BRANCH_W - (n % BRANCH_W));
   endfunction

   function automatic logic [BRANCH_W-1:0] mix(input logic [BRANCH_W-1:0] x);
      return (rotl(x, F_ROT_A) & rotl(x, F_ROT_B)) ^ rotl(x, F_ROT_C);
   endfunction

   // Two identical half-networks: half 0 = (L0,L1), half 1 = (R0,R1)
   for (genvar h = 0; h < 2; h++) begin : g_half
      localparam int TOP  = BLOCK_W - 1 - 2 * h * BRANCH_W;
      localparam int ROT  = (h == 0) ? ROT_L1 : ROT_R1;
      localparam int KA_T = BLOCK_W - 1 - h * BRANCH_W;
      localparam int KB_T = BLOCK_W - 1 - (h + 2) * BRANCH_W;

      logic [BRANCH_W-1:0] x0, x1, ka, kb;
      logic [BRANCH_W-1:0] e_s, e_t, d_t, d_x0, d_x1;

      assign x0 = blk_i[TOP -: BRANCH_W];
      assign x1 = blk_i[TOP - BRANCH_W -: BRANCH_W];
      assign ka = rk_i[KA_T -: BRANCH_W];
      assign kb = rk_i[KB_T -: BRANCH_W];

      always_comb begin
         // forward direction
         e_s  = mix(x0) ^ x1 ^ ka;
         e_t  = mix(e_s) ^ x0 ^ kb;
         if (!last_i) e_t = rotl(e_t, ROT);
         // inverse direction: x0 holds s, x1 holds (rotated) t
         d_t  = last_i ? x1 : rotr(x1, ROT);
         d_x0 = d_t ^ mix(x0) ^ kb;
         d_x1 = x0 ^ mix(d_x0) ^ ka;
      end

      assign blk_o[TOP -: BRANCH_W]            = dec_i ? d_x0 : e_s;
      assign blk_o[TOP - BRANCH_W -: BRANCH_W] = dec_i ? d_x1 : e_t;
   end

endmodule

// File: rtl/arxf_keysched.sv
module arxf_keysched #(
   parameter int BRANCH_W = 8,
   parameter int RC_W     = 5,
   parameter int RC_TAP   = 2,
   parameter int RC_INIT  = 1,
   parameter int RC_POS   = 3,
   parameter int KEY_ROT  = 8,
   localparam int KEY_W   = 8 * BRANCH_W,
   localparam int BLOCK_W = 4 * BRANCH_W,
   localparam int NIB_W   = BRANCH_W / 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               load_i,
   input  logic [KEY_W-1:0]   key_i,
   input  logic               fwd_i,
   input  logic               bwd_i,
   output logic [BLOCK_W-1:0] rk_fwd_o,
   output logic [BLOCK_W-1:0] rk_cur_o
);

   logic [KEY_W-1:0] key_q;
   logic [RC_W-1:0]  rc_q;

   function automatic logic [RC_W-1:0] lfsr_fwd(input logic [RC_W-1:0] r);
      return {r[RC_W-2:0], r[RC_W-1] ^ r[RC_TAP]};
   endfunction

   function automatic logic [RC_W-1:0] lfsr_bwd(input logic [RC_W-1:0] n);
      return {n[0] ^ n[RC_TAP+1], n[RC_W-1:1]};
   endfunction

   function automatic logic [NIB_W-1:0] gate(input logic [NIB_W-1:0] v);
      return v & {v[NIB_W-2:0], v[NIB_W-1]};
   endfunction

   function automatic logic [KEY_W-1:0] add_rc(input logic [KEY_W-1:0] k, input logic [RC_W-1:0] r);
      logic [KEY_W-1:0] w;
      w = '0;
      w[RC_POS +: RC_W] = r;
      return k ^ w;
   endfunction

   function automatic logic [KEY_W-1:0] step_fwd(input logic [KEY_W-1:0] k, input logic [RC_W-1:0] r);
      logic [KEY_W-1:0]  a;
      logic [NIB_W-1:0]  hi, lo;
      a  = add_rc(k, r);
      hi = a[KEY_W-1 -: NIB_W];
      lo = a[KEY_W-1-NIB_W -: NIB_W];
      hi = hi ^ gate(lo);
      lo = lo ^ gate(hi);
      a[KEY_W-1 -: BRANCH_W] = {hi, lo};
      return {a[KEY_W-1-KEY_ROT:0], a[KEY_W-1 -: KEY_ROT]};
   endfunction

   function automatic logic [KEY_W-1:0] step_bwd(input logic [KEY_W-1:0] n, input logic [RC_W-1:0] r);
      logic [KEY_W-1:0]  a;
      logic [NIB_W-1:0]  hi, lo;
      a  = {n[KEY_ROT-1:0], n[KEY_W-1:KEY_ROT]};
      hi = a[KEY_W-1 -: NIB_W];
      lo = a[KEY_W-1-NIB_W -: NIB_W];
      lo = lo ^ gate(hi);
      hi = hi ^ gate(lo);
      a[KEY_W-1 -: BRANCH_W] = {hi, lo};
      return add_rc(a, r);
   endfunction

   logic [KEY_W-1:0] key_next;
   logic [RC_W-1:0]  rc_prev;

   assign key_next = step_fwd(key_q, rc_q);
   assign rc_prev  = lfsr_bwd(rc_q);
   assign rk_fwd_o = key_next[KEY_W-1 -: BLOCK_W];
   assign rk_cur_o = key_q[KEY_W-1 -: BLOCK_W];

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         key_q <= '0;
         rc_q  <= RC_W'(RC_INIT);
      end else if (load_i) begin
         key_q <= key_i;
         rc_q  <= RC_W'(RC_INIT);
      end else if (fwd_i) begin
         key_q <= key_next;
         rc_q  <= lfsr_fwd(rc_q);
      end else if (bwd_i) begin
         key_q <= step_bwd(key_q, rc_prev);
         rc_q  <= rc_prev;
      end
   end

   AST_RC_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni) rc_q != '0); // R5
   AST_BWD_UNDOES_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fwd_i && !load_i) |=> (step_bwd(key_q, lfsr_bwd(rc_q)) == $past(key_q))); // R4

endmodule

// File: rtl/arxf_ctrl.sv
module arxf_ctrl
   import arxf_pkg::*;
#(
   parameter int ROUNDS = 16,
   localparam int CNT_W = $clog2(ROUNDS)
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   input  logic dec_i,
   output logic load_o,
   output logic fwd_o,
   output logic bwd_o,
   output logic step_o,
   output logic last_o,
   output logic fin_o,
   output logic dec_o,
   output logic done_o
);

   phase_e           phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic             dec_q;
   logic             done_q;
   logic             cnt_last;

   assign cnt_last = (cnt_q == CNT_W'(ROUNDS - 1));

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         dec_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (phase_q)
            PH_IDLE: begin
               if (start_i) begin
                  dec_q   <= dec_i;
                  cnt_q   <= '0;
                  phase_q <= dec_i ? PH_PREP : PH_RUN;
               end
            end
            PH_PREP: begin
               if (cnt_last) begin
                  cnt_q   <= '0;
                  phase_q <= PH_RUN;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_RUN: begin
               if (cnt_last) begin
                  cnt_q   <= '0;
                  done_q  <= 1'b1;
                  phase_q <= PH_IDLE;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign load_o = (phase_q == PH_IDLE) && start_i;
   assign fwd_o  = (phase_q == PH_PREP) || ((phase_q == PH_RUN) && !dec_q);
   assign bwd_o  = (phase_q == PH_RUN) && dec_q;
   assign step_o = (phase_q == PH_RUN);
   assign last_o = dec_q ? (cnt_q == '0) : cnt_last;
   assign fin_o  = (phase_q == PH_RUN) && cnt_last;
   assign dec_o  = dec_q;
   assign done_o = done_q;

   AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni) done_q |=> !done_q); // R8
   AST_DONE_AFTER_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni) done_q |-> $past(phase_q == PH_RUN)); // R7
   AST_PREP_THEN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_q == PH_PREP && cnt_last) |=> (phase_q == PH_RUN && cnt_q == '0)); // R7
   AST_BUSY_IGNORES_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_q != PH_IDLE && start_i) |=> $stable(dec_q)); // R9

endmodule

// File: rtl/arxf_core.sv
module arxf_core #(
   parameter int BRANCH_W = 8,
   parameter int ROUNDS   = 16,
   parameter int ROT_L1   = 1,
   parameter int ROT_R1   = 7,
   parameter int RC_W     = 5,
   parameter int RC_TAP   = 2,
   parameter int RC_INIT  = 1,
   parameter int RC_POS   = 3,
   parameter int KEY_ROT  = 8,
   localparam int BLOCK_W = 4 * BRANCH_W,
   localparam int KEY_W   = 8 * BRANCH_W
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               start_i,
   input  logic               decrypt_i,
   input  logic [KEY_W-1:0]   key_i,
   input  logic [BLOCK_W-1:0] block_i,
   output logic [BLOCK_W-1:0] result_o,
   output logic               done_o
);

   // elaboration-time parameter checks
   if (BRANCH_W < 4 || (BRANCH_W % 2) != 0) begin : g_bad_branch
      $error("BRANCH_W must be even and at least 4");
   end
   if (ROUNDS < 2) begin : g_bad_rounds
      $error("ROUNDS must be at least 2");
   end
   if (ROT_L1 <= 0 || ROT_L1 >= BRANCH_W || ROT_R1 <= 0 || ROT_R1 >= BRANCH_W) begin : g_bad_rot
      $error("branch rotations must lie in 1..BRANCH_W-1");
   end
   if (RC_W < 3 || RC_TAP >= RC_W - 1 || RC_INIT == 0 || RC_INIT >= (1 << RC_W)) begin : g_bad_rc
      $error("round-constant LFSR parameters out of range");
   end
   if (RC_POS + RC_W > KEY_W - BRANCH_W) begin : g_bad_rcpos
      $error("round constant field overlaps the nonlinear key byte");
   end
   if (KEY_ROT <= 0 || KEY_ROT >= KEY_W) begin : g_bad_krot
      $error("KEY_ROT must lie in 1..KEY_W-1");
   end

   logic               load, fwd, bwd, step, last, fin, dec_q;
   logic [BLOCK_W-1:0] rk_fwd, rk_cur, rk_sel;
   logic [BLOCK_W-1:0] blk_q, rnd_out, res_q;

   arxf_ctrl #(
      .ROUNDS (ROUNDS)
   ) ctrl_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start_i),
      .dec_i   (decrypt_i),
      .load_o  (load),
      .fwd_o   (fwd),
      .bwd_o   (bwd),
      .step_o  (step),
      .last_o  (last),
      .fin_o   (fin),
      .dec_o   (dec_q),
      .done_o  (done_o)
   );

   arxf_keysched #(
      .BRANCH_W (BRANCH_W),
      .RC_W     (RC_W),
      .RC_TAP   (RC_TAP),
      .RC_INIT  (RC_INIT),
      .RC_POS   (RC_POS),
      .KEY_ROT  (KEY_ROT)
   ) ks_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (load),
      .key_i    (key_i),
      .fwd_i    (fwd),
      .bwd_i    (bwd),
      .rk_fwd_o (rk_fwd),
      .rk_cur_o (rk_cur)
   );

   assign rk_sel = dec_q ? rk_cur : rk_fwd;

   arxf_round #(
      .BRANCH_W (BRANCH_W),
      .ROT_L1   (ROT_L1),
      .ROT_R1   (ROT_R1)
   ) rnd_i (
      .blk_i  (blk_q),
      .rk_i   (rk_sel),
      .dec_i  (dec_q),
      .last_i (last),
      .blk_o  (rnd_out)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         blk_q <= '0;
         res_q <= '0;
      end else begin
         if (load)      blk_q <= block_i;
         else if (step) blk_q <= rnd_out;
         if (fin)       res_q <= rnd_out;
      end
   end

   assign result_o = res_q;

   AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) !done_o |-> $stable(result_o)); // R8
   AST_NO_LOAD_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni) step |-> !load); // R9

endmodule

// File: tb/arxf_core_tb_top.sv
module arxf_core_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        dec = 1'b0;
   logic [63:0] key = '0;
   logic [31:0] blk = '0;
   logic [31:0] result;
   logic        done;

   always #5 clk = ~clk;

   arxf_core dut_i (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .start_i   (start),
      .decrypt_i (dec),
      .key_i     (key),
      .block_i   (blk),
      .result_o  (result),
      .done_o    (done)
   );

   typedef struct {
      logic [31:0] res;
      int          lat;
      int          start_edge;
      string       tag;
   } exp_t;

   exp_t sb[$];
   int   cyc = 0;
   int   n_chk = 0;
   int   n_bad = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   function automatic logic [7:0] m_rotl(input logic [7:0] v, input int n);
      if (n == 0) return v;
      return (v << n) | (v >> (8 - n));
   endfunction

   function automatic logic [7:0] m_f(input logic [7:0] x);
      return (m_rotl(x, 1) & m_rotl(x, 7)) ^ m_rotl(x, 2);
   endfunction

   function automatic logic [4:0] m_lfsr(input logic [4:0] r);
      return {r[3:0], r[4] ^ r[2]};
   endfunction

   function automatic logic [63:0] m_knext(input logic [63:0] k, input logic [4:0] r);
      logic [3:0] h, l;
      k[7:3] = k[7:3] ^ r;
      h = k[63:60];
      l = k[59:56];
      h = h ^ (l & {l[2:0], l[3]});
      l = l ^ (h & {h[2:0], h[3]});
      k[63:56] = {h, l};
      return {k[55:0], k[63:56]};
   endfunction

   function automatic logic [31:0] m_enc(input logic [31:0] p, input logic [63:0] k0);
      logic [63:0] k;
      logic [4:0]  r;
      logic [7:0]  a, b, c, d, s0, s1, t0, t1;
      k = k0; r = 5'b00001;
      {a, b, c, d} = p;
      for (int i = 0; i < 16; i++) begin
         k = m_knext(k, r);
         r = m_lfsr(r);
         s0 = m_f(a) ^ b ^ k[63:56];
         s1 = m_f(c) ^ d ^ k[55:48];
         t0 = m_f(s0) ^ a ^ k[47:40];
         t1 = m_f(s1) ^ c ^ k[39:32];
         if (i != 15) begin t0 = m_rotl(t0, 1); t1 = m_rotl(t1, 7); end
         a = s0; b = t0; c = s1; d = t1;
      end
      return {a, b, c, d};
   endfunction

   function automatic logic [31:0] m_dec(input logic [31:0] cw, input logic [63:0] k0);
      logic [31:0] rks [16];
      logic [63:0] k;
      logic [4:0]  r;
      logic [7:0]  a, b, c, d, x0, x1, y0, y1;
      k = k0; r = 5'b00001;
      for (int i = 0; i < 16; i++) begin
         k = m_knext(k, r);
         r = m_lfsr(r);
         rks[i] = k[63:32];
      end
      {a, b, c, d} = cw;
      for (int i = 15; i >= 0; i--) begin
         if (i != 15) begin b = m_rotl(b, 7); d = m_rotl(d, 1); end
         x0 = b ^ m_f(a) ^ rks[i][15:8];
         x1 = a ^ m_f(x0) ^ rks[i][31:24];
         y0 = d ^ m_f(c) ^ rks[i][7:0];
         y1 = c ^ m_f(y0) ^ rks[i][23:16];
         a = x0; b = x1; c = y0; d = y1;
      end
      return {a, b, c, d};
   endfunction

   // ---------------- monitor ----------------
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R8 unexpected done", result, 32'h0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(result === e.res, e.tag, result, e.res);
            chk((cyc - e.start_edge) == e.lat, "R7 latency", 32'(cyc - e.start_edge), 32'(e.lat));
         end
      end
   end

   // ---------------- driver ----------------
   task automatic run_op(input bit d, input logic [31:0] w, input logic [63:0] k,
                         input logic [31:0] exp, input string tag, input bit poke);
      exp_t e;
      @(negedge clk);
      e.res = exp; e.lat = d ? 32 : 16; e.start_edge = cyc + 1; e.tag = tag;
      sb.push_back(e);
      start = 1'b1; dec = d; blk = w; key = k;
      @(negedge clk);
      start = 1'b0; blk = ~w; key = ~k; dec = ~d;   // R9: late input changes ignored
      if (poke) begin
         repeat (4) @(negedge clk);
         start = 1'b1;                               // R9: start while busy
         @(negedge clk);
         start = 1'b0;
      end
      while (sb.size() != 0) @(negedge clk);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(done === 1'b0, "R8 done pulse width", {31'b0, done}, 32'h0);
         chk(result === exp, "R8 result held", result, exp);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      logic [31:0] p, c;
      logic [63:0] k;
      repeat (3) @(negedge clk);
      chk(done === 1'b0, "R1 done in reset", {31'b0, done}, 32'h0);
      chk(result === 32'h0, "R1 result in reset", result, 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(done === 1'b0, "R1 done after reset", {31'b0, done}, 32'h0);
      chk(result === 32'h0, "R1 result after reset", result, 32'h0);

      // R2 R3 R4 R5 fixed patterns
      run_op(1'b0, 32'h0, 64'h0, m_enc(32'h0, 64'h0), "R2 R4 R5 enc zero", 1'b0);
      run_op(1'b0, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
             m_enc(32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF), "R2 R3 enc ones", 1'b0);
      run_op(1'b0, 32'h0000_0001, 64'h0123_4567_89AB_CDEF,
             m_enc(32'h0000_0001, 64'h0123_4567_89AB_CDEF), "R2 branch map", 1'b0);
      run_op(1'b0, 32'h8000_0000, 64'h8000_0000_0000_0000,
             m_enc(32'h8000_0000, 64'h8000_0000_0000_0000), "R3 R4 key top byte", 1'b0);
      run_op(1'b1, m_enc(32'hAD75_EAB3, 64'h7907_47A6_CD32_E63C), 64'h7907_47A6_CD32_E63C,
             32'hAD75_EAB3, "R6 dec fixed", 1'b0);

      // R9 start while busy, both directions
      run_op(1'b0, 32'h1234_5678, 64'hDEAD_BEEF_0BAD_F00D,
             m_enc(32'h1234_5678, 64'hDEAD_BEEF_0BAD_F00D), "R9 enc busy start", 1'b1);
      run_op(1'b1, 32'h1234_5678, 64'hDEAD_BEEF_0BAD_F00D,
             m_dec(32'h1234_5678, 64'hDEAD_BEEF_0BAD_F00D), "R9 dec busy start", 1'b1);

      // random round trips
      for (int n = 0; n < 24; n++) begin
         p = $urandom();
         k = {$urandom(), $urandom()};
         c = m_enc(p, k);
         chk(m_dec(c, k) === p, "R6 model self-inverse", m_dec(c, k), p);
         run_op(1'b0, p, k, c, "R2 R3 enc random", n[0]);
         run_op(1'b1, c, k, p, "R6 dec random", n[1]);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule